// File: doc/BRIEF.md
# Percussion Noise and Phase Generator

This block supplies the pseudo-random noise bit and the three quantized phase words used by the noisy and metallic percussion voices of an FM synthesizer: the hi-hat, the snare and the top cymbal. A 23-bit linear feedback register advances once per sample step. Its low bit is combined with selected bits of two operator phase counters. Operator A is operator 1 of channel 7, and operator B is operator 2 of channel 8. The result is a set of 10-bit phase words that a downstream sine lookup turns into sound.

The surrounding synthesizer raises `step` for one clock per output sample and presents the integer parts of the two operator phases on the same cycle. On the next clock the block presents the new noise bit and the three phase words. These values hold until the next step.

Top module: `perc_noise_phase`

## Requirements
- R1: While reset is asserted and after it is released, before any step, `noise` is 1 and `hat_phase`, `snare_phase` and `cymbal_phase` are all zero. The internal noise register holds the value 1.
- R2: On each step the 23-bit noise register is updated as follows: if its bit 0 is 1, it is XORed with 0x800302 (taken as 24 bits), and then it is shifted right by one place. `noise` shows bit 0 of the updated register.
- R3: All four outputs change only on the clock edge where `step` is sampled high. With `step` low, changes on `phase_a` and `phase_b` have no effect on any output.
- R4: The metallic term is m = ((A[2] XOR A[7]) OR A[3]) OR (B[3] XOR B[5]). Here A and B are the 10-bit phases sampled at the step. `cymbal_phase` is 0x300 when m is 1 and 0x100 when m is 0, whatever the value of `noise`.
- R5: When the new noise bit is 0, `hat_phase` is 0x234 if m is 1 and 0x0D0 if m is 0. When the new noise bit is 1, `hat_phase` is 0x2D0 if m is 1 and 0x034 if m is 0.
- R6: `snare_phase` is 0x200 when A[8] is 1 and 0x100 when A[8] is 0. This value is then XORed with 0x100 when the new noise bit is 1.
- R7: The noise register never reaches the all-zero state, so the noise sequence never sticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle strobe that advances by one sample |
| phase_a | input | 10 | Integer phase of channel 7 operator 1 |
| phase_b | input | 10 | Integer phase of channel 8 operator 2 |
| noise | output | 1 | Current noise bit |
| hat_phase | output | 10 | Hi-hat phase word |
| snare_phase | output | 10 | Snare phase word |
| cymbal_phase | output | 10 | Top-cymbal phase word |

## Verification
The hardest case to reach is a chosen operator-phase pattern paired with a chosen noise value. The noise bit comes from an internal register that cannot be loaded from the ports. The bench keeps its own copy of the register sequence and, before each pattern, looks one step ahead. It inserts idle steps until the next noise bit has the wanted value, and only then applies the pattern. In this way every combination of the six significant operator bits is checked under both noise values.

// File: rtl/perc_noise_phase.sv
module perc_noise_phase #(
  parameter int LFSR_W = 23,
  parameter int PH_W   = 10,
  parameter logic [LFSR_W-1:0] SEED = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [PH_W-1:0] phase_a,
  input  logic [PH_W-1:0] phase_b,
  output logic            noise,
  output logic [PH_W-1:0] hat_phase,
  output logic [PH_W-1:0] snare_phase,
  output logic [PH_W-1:0] cymbal_phase
);

  localparam logic [LFSR_W-2:0] FOLD = (LFSR_W-1)'(9'h181);
  localparam logic [PH_W-1:0] HAT_LO   = PH_W'(10'h0D0);
  localparam logic [PH_W-1:0] HAT_HI   = PH_W'(10'h234);
  localparam logic [PH_W-1:0] HAT_LO_N = PH_W'(10'h034);
  localparam logic [PH_W-1:0] HAT_HI_N = PH_W'(10'h2D0);
  localparam logic [PH_W-1:0] SN_LO    = PH_W'(10'h100);
  localparam logic [PH_W-1:0] SN_HI    = PH_W'(10'h200);
  localparam logic [PH_W-1:0] CY_LO    = PH_W'(10'h100);
  localparam logic [PH_W-1:0] CY_HI    = PH_W'(10'h300);

  logic [LFSR_W-1:0] lfsr, lfsr_nx;
  logic              nz, metal;
  logic [PH_W-1:0]   hat_nx, snare_nx, cym_nx;

  assign lfsr_nx = {lfsr[0], lfsr[LFSR_W-1:1] ^ (FOLD & {(LFSR_W-1){lfsr[0]}})};
  assign nz      = lfsr_nx[0];
  assign metal   = ((phase_a[2] ^ phase_a[7]) | phase_a[3]) | (phase_b[3] ^ phase_b[5]);

  always_comb begin
    if (nz) hat_nx = metal ? HAT_HI_N : HAT_LO_N;
    else    hat_nx = metal ? HAT_HI   : HAT_LO;
  end

  assign snare_nx = (phase_a[8] ? SN_HI : SN_LO) ^ (nz ? PH_W'(10'h100) : '0);
  assign cym_nx   = metal ? CY_HI : CY_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr         <= SEED;
      hat_phase    <= '0;
      snare_phase  <= '0;
      cymbal_phase <= '0;
    end else if (step) begin
      lfsr         <= lfsr_nx;
      hat_phase    <= hat_nx;
      snare_phase  <= snare_nx;
      cymbal_phase <= cym_nx;
    end
  end

  assign noise = lfsr[0];

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step) |-> ($stable(hat_phase) && $stable(snare_phase) &&
                      $stable(cymbal_phase) && $stable(noise)));

  assert_cymbal_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) |-> (cymbal_phase == CY_LO || cymbal_phase == CY_HI));

  assert_hat_cym_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hat_phase[PH_W-1] == cymbal_phase[PH_W-1]);

  assert_snare_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) |-> (snare_phase[9] == $past(phase_a[8]) &&
                     snare_phase[8] == (!$past(phase_a[8]) ^ noise) &&
                     snare_phase[7:0] == '0));

endmodule

// File: tb/tb_perc_noise_phase.sv
module tb_perc_noise_phase;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       step = 0;
  logic [9:0] phase_a = '0, phase_b = '0;
  logic       noise;
  logic [9:0] hat_phase, snare_phase, cymbal_phase;

  int total = 0, bad = 0;
  logic [22:0] model = 23'd1;
  logic [9:0]  exp_hat, exp_snare, exp_cym;
  logic        done = 0;

  perc_noise_phase dut (
    .clk(clk), .rst_n(rst_n), .step(step),
    .phase_a(phase_a), .phase_b(phase_b),
    .noise(noise), .hat_phase(hat_phase),
    .snare_phase(snare_phase), .cymbal_phase(cymbal_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] adv(input logic [22:0] m);
    logic [23:0] w;
    w = {1'b0, m};
    if (w[0]) w = w ^ 24'h800302;
    return w[23:1];
  endfunction

  function automatic logic mterm(input logic [9:0] a, input logic [9:0] b);
    return ((a[2] ^ a[7]) | a[3]) | (b[3] ^ b[5]);
  endfunction

  task automatic do_step(input logic [9:0] a, input logic [9:0] b);
    logic m;
    @(negedge clk);
    phase_a = a; phase_b = b; step = 1;
    @(negedge clk);
    step = 0;
    model = adv(model);
    m = mterm(a, b);
    exp_cym   = m ? 10'h300 : 10'h100;
    exp_hat   = model[0] ? (m ? 10'h2D0 : 10'h034) : (m ? 10'h234 : 10'h0D0);
    exp_snare = (a[8] ? 10'h200 : 10'h100) ^ (model[0] ? 10'h100 : 10'h000);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 noise in reset", noise, 1);
    check("R1 hat in reset", hat_phase, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 noise after reset", noise, 1);
    check("R1 hat after reset", hat_phase, 0);
    check("R1 snare after reset", snare_phase, 0);
    check("R1 cymbal after reset", cymbal_phase, 0);
  endtask

  task automatic t_noise_seq();
    // R2, R7: first steps from seed 1: 0x400181 -> noise 1
    for (int i = 0; i < 400; i++) begin
      do_step(10'($urandom), 10'($urandom));
      check("R2 noise sequence", noise, model[0]);
    end
    check("R7 model register nonzero", (model != 0), 1);
  endtask

  task automatic t_hold();
    logic n0;
    logic [9:0] h0, s0, c0;
    do_step(10'h000, 10'h000);
    n0 = noise; h0 = hat_phase; s0 = snare_phase; c0 = cymbal_phase;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      phase_a = 10'($urandom); phase_b = 10'($urandom);
      @(negedge clk);
      check("R3 noise held", noise, n0);
      check("R3 hat held", hat_phase, h0);
      check("R3 snare held", snare_phase, s0);
      check("R3 cymbal held", cymbal_phase, c0);
    end
  endtask

  task automatic t_patterns();
    for (int nv = 0; nv < 2; nv++) begin
      for (int k = 0; k < 64; k++) begin
        logic [9:0] a, b;
        while (adv(model)[0] != nv[0]) do_step(10'($urandom), 10'($urandom));
        a = 10'($urandom); b = 10'($urandom);
        a[2] = k[0]; a[3] = k[1]; a[7] = k[2]; a[8] = k[3];
        b[3] = k[4]; b[5] = k[5];
        do_step(a, b);
        check("R2 noise value", noise, nv);
        check("R4 cymbal phase", cymbal_phase, exp_cym);
        check("R5 hat phase", hat_phase, exp_hat);
        check("R6 snare phase", snare_phase, exp_snare);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_noise_seq();
    t_hold();
    t_patterns();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule